// File: doc/BRIEF.md
# Pipelined Microprogram Sequencer with OR-Merge Branching

This block steps through a horizontal microprogram kept in an on-chip read-only table. Each microword names its own successor through an 8-bit next-address field. A 5-bit test field picks one condition source: the low mode bits of the current instruction, the zero flag, the carry flag or a pending interrupt. The bits of that source, zero-extended to 8 bits, are ORed into the successor address. There is no incrementer and no return stack. Branch targets therefore have to sit at addresses whose merged bits are zero in the stored next-address field.

Two registers overlap fetch with execution. The ROM address register holds the address being fetched, and the control word register holds the word being executed. On every cycle-end strobe, the fetched word moves into the control word register and the merged address moves into the ROM address register. A condition sampled while a word executes therefore steers the word executed two strobes later. When the strobe is low, both registers hold, which models a stopped clock. The sequencer also selects a 4-bit register-file index from one of four sources chosen by the executing word.

Top module: `microseq_top`

## Requirements
- R1: While `rst_n` is low, `ctrl_word` is all zeros and the ROM address register is 0. As a result, the first strobe after reset loads the word stored at address 0.
- R2: On a strobe with `cyc_end` high, `ctrl_word` takes the ROM word at the address held before that strobe.
- R3: The new ROM address is the next-address field bitwise ORed with the selected condition bits. Test code 0 leaves the field unchanged, and an OR never clears a bit of the field.
- R4: Test code 1 merges instruction bits [5:3], code 2 merges the zero flag into bit 0, code 3 merges the carry flag into bit 0, and code 4 merges the interrupt-pending flag into bit 0. Every other code merges nothing.
- R5: A condition present at the strobe that ends cycle n decides the word that appears on `ctrl_word` after the following strobe, which is the word executed in cycle n+2.
- R6: With `cyc_end` low, `ctrl_word` and the ROM address register hold their values, whatever the other inputs do.
- R7: `reg_idx` follows the 2-bit source code in the executing word: 0 selects instruction bits [8:6] zero-extended, 1 selects instruction bits [2:0] zero-extended, 2 selects the word's 4-bit immediate, and 3 selects bus-address bits [3:0].
- R8: The microword fields are placed as follows: next address in [7:0], test code in [12:8], immediate in [16:13], index source in [18:17], and the remaining control payload in [55:19].
- R9: The word at address a (8 bits) holds:
  - next address `{a[7:3]+1, 3'b000}` (modulo 256);
  - test code `a[5:3]`;
  - immediate `a[3:0] XOR 4'hA`;
  - index source `(a[1:0]+a[4:3]) mod 4`;
  - payload `{a[4:0], ~a, a, ~a, a}`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cyc_end | input | 1 | Cycle-end strobe; the pipeline advances only when it is high |
| ir_fields | input | 9 | Instruction bits [8:0] (source register, mode, destination register) |
| ba_lo | input | 4 | Bus address bits [3:0] |
| flag_z | input | 1 | Zero flag condition |
| flag_c | input | 1 | Carry flag condition |
| irq_pend | input | 1 | Interrupt-pending condition |
| ctrl_word | output | 56 | Executing microword |
| reg_idx | output | 4 | Register-file index |

## Verification
The hardest effect to reach is the two-strobe lag. A condition only becomes visible as a changed `ctrl_word` one strobe after the strobe that sampled it, and only if the executing word carries a test code whose merged bits actually differ from the stored address. The program walks through blocks of eight addresses whose test codes cycle through every source. The stimulus redraws the instruction bits and the flags before every strobe and inserts held cycles between strobes. A reference model of both pipeline registers, kept in the bench, therefore sees each condition source steer the sequence under many different values, including values that change while the pipeline is stalled.

// File: rtl/microseq_pkg.sv
package microseq_pkg;

  localparam int UW    = 56;  // microword width
  localparam int AW    = 8;   // ROM address / next-address field width
  localparam int TW    = 5;   // branch-test field width
  localparam int IMMW  = 4;   // immediate register field width
  localparam int RSW   = 2;   // register-index source code width
  localparam int RIW   = 4;   // register-file index width
  localparam int IRW   = 9;   // instruction bits brought in
  localparam int BAW   = 4;   // bus address bits brought in
  localparam int PAYW  = UW - AW - TW - IMMW - RSW;
  localparam int DEPTH = 1 << AW;

  // branch-test codes
  localparam logic [TW-1:0] TST_NONE = TW'(0);
  localparam logic [TW-1:0] TST_MODE = TW'(1);
  localparam logic [TW-1:0] TST_ZERO = TW'(2);
  localparam logic [TW-1:0] TST_CARY = TW'(3);
  localparam logic [TW-1:0] TST_IRQ  = TW'(4);

  // register index sources
  typedef enum logic [RSW-1:0] {
    RS_SRC = 2'd0,
    RS_DST = 2'd1,
    RS_IMM = 2'd2,
    RS_BA  = 2'd3
  } rsrc_e;

  typedef struct packed {
    logic [PAYW-1:0] payload;
    rsrc_e           rsel;
    logic [IMMW-1:0] imm;
    logic [TW-1:0]   test;
    logic [AW-1:0]   nxt;
  } uword_t;

  // Content of the control store, computed per address.
  function automatic uword_t rom_word(input logic [AW-1:0] a);
    uword_t              w;
    logic [AW-4:0]       blk;
    logic [5*AW-1:0]     pat;
    blk       = a[AW-1:3] + 1'b1;
    w.nxt     = {blk, 3'b000};
    w.test    = TW'(a[5:3]);
    w.imm     = a[3:0] ^ 4'hA;
    w.rsel    = rsrc_e'(a[1:0] + a[4:3]);
    pat       = {a, ~a, a, ~a, a};
    w.payload = pat[PAYW-1:0];
    return w;
  endfunction

  // Condition bits merged into the next address for a given test code.
  function automatic logic [AW-1:0] cond_bits(
    input logic [TW-1:0] code,
    input logic [2:0]    mode_lo,
    input logic          z,
    input logic          c,
    input logic          irq
  );
    logic [AW-1:0] r;
    case (code)
      TST_MODE: r = AW'(mode_lo);
      TST_ZERO: r = AW'(z);
      TST_CARY: r = AW'(c);
      TST_IRQ:  r = AW'(irq);
      default:  r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/microseq_rom.sv
module microseq_rom
  import microseq_pkg::*;
#(
  parameter int ADDR_W = AW
) (
  input  logic [ADDR_W-1:0] addr,
  output uword_t            data
);

  localparam int N = 1 << ADDR_W;

  uword_t tbl [N];

  generate
    for (genvar i = 0; i < N; i++) begin : g_word
      assign tbl[i] = rom_word(AW'(i));
    end
  endgenerate

  assign data = tbl[addr];

endmodule

// File: rtl/microseq_merge.sv
module microseq_merge
  import microseq_pkg::*;
(
  input  logic [AW-1:0]  nxt_field,
  input  logic [TW-1:0]  test_code,
  input  logic [IRW-1:0] ir_fields,
  input  logic           flag_z,
  input  logic           flag_c,
  input  logic           irq_pend,
  output logic [AW-1:0]  cond_val,
  output logic [AW-1:0]  merged_addr
);

  assign cond_val    = cond_bits(test_code, ir_fields[5:3], flag_z, flag_c, irq_pend);
  assign merged_addr = nxt_field | cond_val;

endmodule

// File: rtl/microseq_regsel.sv
module microseq_regsel
  import microseq_pkg::*;
(
  input  rsrc_e           rsel,
  input  logic [IMMW-1:0] imm,
  input  logic [IRW-1:0]  ir_fields,
  input  logic [BAW-1:0]  ba_lo,
  output logic [RIW-1:0]  reg_idx
);

  always_comb begin
    case (rsel)
      RS_SRC:  reg_idx = RIW'(ir_fields[8:6]);
      RS_DST:  reg_idx = RIW'(ir_fields[2:0]);
      RS_IMM:  reg_idx = RIW'(imm);
      default: reg_idx = RIW'(ba_lo);
    endcase
  end

endmodule

// File: rtl/microseq_top.sv
module microseq_top
  import microseq_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cyc_end,
  input  logic [IRW-1:0] ir_fields,
  input  logic [BAW-1:0] ba_lo,
  input  logic           flag_z,
  input  logic           flag_c,
  input  logic           irq_pend,
  output logic [UW-1:0]  ctrl_word,
  output logic [RIW-1:0] reg_idx
);

  logic [AW-1:0] rom_addr_q;   // address being fetched
  uword_t        cw_q;         // word being executed
  uword_t        rom_data;
  logic [AW-1:0] cond_val;
  logic [AW-1:0] next_addr;

  microseq_rom #(.ADDR_W(AW)) u_rom (
    .addr (rom_addr_q),
    .data (rom_data)
  );

  microseq_merge u_merge (
    .nxt_field   (cw_q.nxt),
    .test_code   (cw_q.test),
    .ir_fields   (ir_fields),
    .flag_z      (flag_z),
    .flag_c      (flag_c),
    .irq_pend    (irq_pend),
    .cond_val    (cond_val),
    .merged_addr (next_addr)
  );

  microseq_regsel u_regsel (
    .rsel      (cw_q.rsel),
    .imm       (cw_q.imm),
    .ir_fields (ir_fields),
    .ba_lo     (ba_lo),
    .reg_idx   (reg_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rom_addr_q <= '0;
      cw_q       <= '0;
    end else if (cyc_end) begin
      rom_addr_q <= next_addr;
      cw_q       <= rom_data;
    end
  end

  assign ctrl_word = cw_q;

endmodule

// File: rtl/microseq_chk.sv
module microseq_chk
  import microseq_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           cyc_end,
  input logic [AW-1:0]  rar,
  input logic [UW-1:0]  ctrl_word,
  input logic [RIW-1:0] reg_idx,
  input logic [BAW-1:0] ba_lo,
  input logic           flag_z,
  input logic           irq_pend
);

  logic [AW-1:0]   f_nxt;
  logic [TW-1:0]   f_test;
  logic [IMMW-1:0] f_imm;
  logic [RSW-1:0]  f_rsel;
  assign f_nxt  = ctrl_word[7:0];
  assign f_test = ctrl_word[12:8];
  assign f_imm  = ctrl_word[16:13];
  assign f_rsel = ctrl_word[18:17];

  AST_RESET_NOP: assert property (@(posedge clk) !rst_n |=> ctrl_word == '0); // R1
  AST_FETCH_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> ctrl_word == UW'(rom_word($past(rar)))); // R2
  AST_PLAIN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && (f_test == TST_NONE || f_test > TST_IRQ) |=> rar == $past(f_nxt)); // R3
  AST_OR_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (rar & $past(f_nxt)) == $past(f_nxt)); // R3
  AST_ZERO_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && f_test == TST_ZERO |=> rar[0] == ($past(f_nxt[0]) | $past(flag_z))); // R4
  AST_IRQ_MERGE: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end && f_test == TST_IRQ |=> rar[0] == ($past(f_nxt[0]) | $past(irq_pend))); // R4
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(ctrl_word)); // R6
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_end |=> $stable(rar)); // R6
  AST_IDX_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    f_rsel == 2'd2 |-> reg_idx == f_imm); // R7
  AST_IDX_BA: assert property (@(posedge clk) disable iff (!rst_n)
    f_rsel == 2'd3 |-> reg_idx == ba_lo); // R7

endmodule

bind microseq_top microseq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cyc_end   (cyc_end),
  .rar       (rom_addr_q),
  .ctrl_word (ctrl_word),
  .reg_idx   (reg_idx),
  .ba_lo     (ba_lo),
  .flag_z    (flag_z),
  .irq_pend  (irq_pend)
);

// File: tb/test_microseq_top.sv
module test_microseq_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_end = 1'b0;
  logic [8:0]  ir_fields = '0;
  logic [3:0]  ba_lo = '0;
  logic        flag_z = 1'b0;
  logic        flag_c = 1'b0;
  logic        irq_pend = 1'b0;
  logic [55:0] ctrl_word;
  logic [3:0]  reg_idx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  microseq_top i_microseq_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .cyc_end   (cyc_end),
    .ir_fields (ir_fields),
    .ba_lo     (ba_lo),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .irq_pend  (irq_pend),
    .ctrl_word (ctrl_word),
    .reg_idx   (reg_idx)
  );

  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    logic [55:0] cw;
    logic [3:0]  idx;
    string       tag;
  } exp_t;

  exp_t q[$];

  // bench model state
  logic [7:0]  m_addr;
  logic [55:0] m_word;

  // control store restated from R9 with R8 placement
  function automatic logic [55:0] ref_word(input logic [7:0] a);
    logic [7:0] nx;
    logic [4:0] tc;
    logic [3:0] im;
    logic [1:0] rs;
    nx = 8'(((a >> 3) + 8'd1) << 3);
    tc = 5'((a >> 3) & 8'h07);
    im = 4'((a & 8'h0F) ^ 8'h0A);
    rs = 2'((a + (a >> 3)) & 8'h03);
    return {a[4:0], ~a, a, ~a, a, rs, im, tc, nx};
  endfunction

  function automatic logic [7:0] ref_cond(input logic [4:0] code);
    if (code == 5'd1) return {5'd0, ir_fields[5:3]};
    if (code == 5'd2) return {7'd0, flag_z};
    if (code == 5'd3) return {7'd0, flag_c};
    if (code == 5'd4) return {7'd0, irq_pend};
    return 8'd0;
  endfunction

  function automatic logic [3:0] ref_idx(input logic [55:0] w);
    case (w[18:17])
      2'd0:    return {1'b0, ir_fields[8:6]};
      2'd1:    return {1'b0, ir_fields[2:0]};
      2'd2:    return w[16:13];
      default: return ba_lo;
    endcase
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // driver: one cycle, with or without the cycle-end strobe
  task automatic step(input bit adv);
    exp_t e;
    logic [4:0] code;
    @(negedge clk);
    ir_fields = 9'($urandom);
    ba_lo     = 4'($urandom);
    flag_z    = 1'($urandom);
    flag_c    = 1'($urandom);
    irq_pend  = 1'($urandom);
    cyc_end   = adv;
    code      = m_word[12:8];
    if (adv) begin
      e.tag  = (code == 5'd0 || code > 5'd4) ? "R2 R3 R5 R8 R9" : "R2 R4 R5 R8 R9";
      m_addr = m_word[7:0] | ref_cond(code);
      m_word = ref_word(q.size() == 0 ? m_addr_prev : m_addr_prev);
    end else begin
      e.tag = "R6";
    end
    e.cw  = m_word;
    e.idx = ref_idx(m_word);
    q.push_back(e);
  endtask

  // address fetched before the current strobe (needed by step)
  logic [7:0] m_addr_prev;

  task automatic step_w(input bit adv);
    m_addr_prev = m_addr;
    step(adv);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " ctrl_word"}, 64'(ctrl_word), 64'(e.cw));
        check("R7 reg_idx", 64'(reg_idx), 64'(e.idx));
      end
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_addr = '0;
    m_word = '0;
    m_addr_prev = '0;
    repeat (3) @(negedge clk);
    ir_fields = 9'o712;
    #1;
    check("R1 reset ctrl_word", 64'(ctrl_word), 64'd0);
    check("R1 R7 reset reg_idx", 64'(reg_idx), 64'd7);
    @(negedge clk);
    rst_n = 1'b1;
    // first strobe after reset must load the word at address 0 (R1)
    step_w(1'b1);
    @(posedge clk);
    #2;
    check("R1 first word", 64'(ctrl_word), 64'(ref_word(8'd0)));
    // directed hold while inputs move (R6)
    repeat (4) step_w(1'b0);
    // long mixed run
    for (int i = 0; i < 3000; i++) begin
      step_w(($urandom % 4) != 0);
    end
    @(negedge clk);
    cyc_end = 1'b0;
    repeat (2) @(posedge clk);
    #2;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule